// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write single bytes in an asynchronous static RAM. The RAM has four control pins: an active-high chip enable, an active-low chip select, an active-low write strobe and an active-low output enable. Its data bus is presented here as three separate signals: a data-out value, a drive-enable for it, and a data-in value. The pad-level tristate is left to the chip top. Every analog timing limit of the RAM is given to the block as a nanosecond parameter. The block converts each one to clock cycles by rounding up against the clock-period parameter.

The host side is a request port with valid/ready handshake rules. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The block then captures the direction, the address and the write data. It drops `req_ready` for the whole RAM cycle, and the host holds back further requests until `req_ready` returns. The read return has no back-pressure. `rsp_valid` is a single-cycle pulse, and the host must take `rsp_rdata` in that cycle.

Between any two accesses the block parks the RAM in its low-power deselected state. This also gives the control toggle the RAM needs between back-to-back writes.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and whenever no cycle is in progress, the block holds the idle pin state: `req_ready`=1, `sram_cs_n`=1, `sram_ce`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0. An asynchronous reset in the middle of a write returns the pins to this state at once.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the cycle completes. Changes to `req_write`, `req_addr` and `req_wdata` after acceptance have no effect on the cycle.
- R3: A read (`req_write`=0) drives, for RD_CYC cycles starting at the edge of acceptance: `sram_cs_n`=0, `sram_ce`=1, `sram_oe_n`=0, `sram_we_n`=1, `sram_dq_oe`=0, and `sram_addr` equal to the accepted address.
- R4: `sram_dq_in` is sampled at the edge that ends the read window. `rsp_valid` is then high for exactly one cycle, with that byte on `rsp_rdata`, and `req_ready` is high in the same cycle.
- R5: A write (`req_write`=1) first spends one selected cycle with `sram_we_n`=1. It then holds `sram_we_n`=0 for WP_CYC cycles. `sram_oe_n` stays 1 for the whole write, and `sram_we_n` is never low unless `sram_cs_n`=0 and `sram_ce`=1.
- R6: `sram_dq_oe` is high exactly while `sram_we_n` is low plus the first cycle after it rises. During that time `sram_dq_out` equals the accepted write data.
- R7: `sram_addr` holds the accepted address from the select cycle until the data-hold cycle after the write strobe rises.
- R8: After each cycle the RAM is deselected (`sram_cs_n`=1) for at least one cycle before the next cycle starts. Successive write strobes are separated by at least REC_CYC cycles with `sram_we_n` high.
- R9: The cycle counts are ceilings of the nanosecond limits. With a 5 ns clock they are RD_CYC=5, WP_CYC=4 and REC_CYC=1. With the default 10 ns clock they are 3, 2 and 1.
- R10: A write never produces `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce | output | 1 | RAM chip enable, active high |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data from the RAM |

## Verification
The hardest case to reach is an asynchronous reset that lands inside a write strobe. In that case the strobe, the data drive and the chip select must all drop together, with no data-hold cycle, and the next request must still run normally. The bench reaches it with a directed sequence: it counts negative edges from the acceptance of a write into the strobe window, pulls reset there, and checks the pins before the next clock edge. A second hard case is a pair of back-to-back writes presented the moment `req_ready` rises. There, a pin monitor measures the high gap of the write strobe and confirms that chip select rose between the two strobes.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_WR_SETUP = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_REC   = 3'd4
  } ctrl_state_e;

  // Round a nanosecond limit up to whole clock periods given in picoseconds.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  // R4: the read strobe never lasts two cycles
  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int RD_CYC  = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_last,
  output logic              rd_capture,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  ctrl_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            tmr_val = '0;
          end else begin
            state_d = ST_RD_ACC;
            tmr_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        if (tmr_last) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (tmr_last) begin
          state_d  = ST_WR_REC;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WR_REC: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rd_capture = (state_q == ST_RD_ACC) && tmr_last;

  // State and RAM pins are registered together so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sram_cs_n  <= 1'b1;
      sram_ce    <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      state_q    <= state_d;
      sram_cs_n  <= (state_d == ST_IDLE);
      sram_ce    <= (state_d != ST_IDLE);
      sram_we_n  <= (state_d != ST_WR_PULSE);
      sram_oe_n  <= (state_d != ST_RD_ACC);
      sram_dq_oe <= (state_d == ST_WR_PULSE) ||
                    ((state_d == ST_WR_REC) && (state_q == ST_WR_PULSE));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
    end else if (req_ready && req_valid) begin
      sram_addr   <= req_addr;
      sram_dq_out <= req_wdata;
    end
  end

  // Run-length counters of the write strobe, used by the timing checks below.
  logic [7:0] lo_run, hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else if (sram_we_n) begin
      lo_run <= '0;
      if (hi_run != 8'hFF) hi_run <= hi_run + 8'd1;
    end else begin
      hi_run <= '0;
      if (lo_run != 8'hFF) lo_run <= lo_run + 8'd1;
    end
  end

  // R1: idle means deselected
  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && !sram_ce && sram_we_n && !sram_dq_oe));

  // R3: read enables never overlap a write strobe or the data drive
  p_read_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_dq_oe && !sram_cs_n && sram_ce));

  // R5: strobe only while selected, outputs held off, data driven
  p_write_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_ce && sram_oe_n && sram_dq_oe));

  // R5: a selected cycle precedes the falling strobe
  p_setup_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_cs_n && sram_we_n));

  // R9: strobe width in cycles
  p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (lo_run >= 8'(WP_CYC)));

  // R6: data still driven in the cycle after the strobe rises
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  // R7: address frozen across the strobe and into the hold cycle
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> $stable(sram_addr));

  // R8: recovery gap between strobes
  p_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (hi_run >= 8'(REC_CYC)));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_PS  = 10000,
  parameter int T_CYCLE_NS     = 25,
  parameter int T_ACCESS_NS    = 25,
  parameter int T_OE_ACCESS_NS = 9,
  parameter int T_WP_NS        = 20,
  parameter int T_DW_NS        = 15,
  parameter int T_AW_NS        = 20,
  parameter int T_REC_NS       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int CYC_C  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_PS);
  localparam int RD_CYC = imax(imax(CYC_C, ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_PS)),
                               imax(ns_to_cyc(T_OE_ACCESS_NS, CLK_PERIOD_PS), 1));
  // The select cycle already counts toward address-valid-to-strobe-end.
  localparam int WP_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_PS),
                                    ns_to_cyc(T_DW_NS, CLK_PERIOD_PS)),
                               imax(ns_to_cyc(T_AW_NS, CLK_PERIOD_PS) - 1, 1));
  localparam int REC_CYC = imax(imax(ns_to_cyc(T_REC_NS, CLK_PERIOD_PS), 1),
                                CYC_C - 1 - WP_CYC);
  localparam int CNT_W = $clog2(imax(imax(RD_CYC, WP_CYC), REC_CYC) + 1);

  logic             tmr_load, tmr_last, rd_capture;
  logic [CNT_W-1:0] tmr_val;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_ctrl_fsm #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC), .REC_CYC (REC_CYC), .CNT_W (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_last    (tmr_last),
    .rd_capture  (rd_capture),
    .sram_addr   (sram_addr),
    .sram_ce     (sram_ce),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_capture),
    .dq_in     (sram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R10: a read strobe only follows a read window, never a write
  p_no_wr_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RD = 5;   // R9: 25 ns read window at 5 ns clock
  localparam int WP = 4;   // R9: 20 ns strobe at 5 ns clock
  localparam int RC = 1;   // R9: 5 ns recovery at 5 ns clock
  localparam logic [7:0] BLANK = 8'hE7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic sram_ce, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out, sram_dq_in;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(5000)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce(sram_ce), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural RAM: stores on the rising strobe, drives when read-enabled.
  logic [7:0] mem [int];
  function automatic logic [7:0] lookup(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return BLANK;
  endfunction
  always_comb begin
    if (!sram_cs_n && sram_ce && !sram_oe_n && sram_we_n) sram_dq_in = lookup(sram_addr);
    else sram_dq_in = 8'h00;
  end

  // Pin monitor at negative edges.
  bit mon_en = 1'b0;
  logic prev_we = 1'b1;
  int hi_gap = 0;
  bit saw_desel = 1'b1;
  always @(negedge clk) begin
    if (mon_en) begin
      if (sram_cs_n) saw_desel = 1'b1;
      if (!prev_we && sram_we_n) begin
        chk(sram_dq_oe, "R6 hold drive", sram_dq_oe, 1);
        if (sram_dq_oe) mem[int'(sram_addr)] = sram_dq_out;
      end
      if (prev_we && !sram_we_n) begin
        chk(hi_gap >= RC, "R8 gap", hi_gap, RC);
        chk(saw_desel, "R8 toggle", saw_desel, 1);
        saw_desel = 1'b0;
      end
      if (sram_we_n) hi_gap++; else hi_gap = 0;
    end
    prev_we = sram_we_n;
  end

  // Entered and left at a negative edge.
  task automatic do_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(req_ready, "R2 ready idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    chk(!req_ready, "R2 busy", req_ready, 0);
    chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
    if (!wr) begin
      for (int k = 1; k <= RD; k++) begin
        chk(!sram_cs_n && sram_ce && !sram_oe_n && sram_we_n && !sram_dq_oe,
            "R3 read pins", {sram_cs_n, sram_ce, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b01010);
        chk(sram_addr == a, "R3 addr", sram_addr, a);
        chk(!rsp_valid, "R9 read window", rsp_valid, 0);
        @(negedge clk);
      end
      chk(rsp_valid, "R4 valid", rsp_valid, 1);
      chk(rsp_rdata == d, "R4 data", rsp_rdata, d);
      chk(req_ready && sram_cs_n, "R8 deselect", {req_ready, sram_cs_n}, 2'b11);
    end else begin
      chk(!sram_cs_n && sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe,
          "R5 setup", {sram_cs_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b01110);
      @(negedge clk);
      for (int k = 1; k <= WP; k++) begin
        chk(!sram_we_n && sram_oe_n && !sram_cs_n, "R5 strobe",
            {sram_we_n, sram_oe_n, sram_cs_n}, 3'b010);
        chk(sram_dq_oe && sram_dq_out == d, "R6 data", sram_dq_out, d);
        chk(sram_addr == a, "R7 addr", sram_addr, a);
        chk(!rsp_valid, "R10 no rsp", rsp_valid, 0);
        @(negedge clk);
      end
      chk(sram_we_n, "R9 strobe end", sram_we_n, 1);
      chk(sram_dq_oe && sram_dq_out == d, "R6 hold", sram_dq_out, d);
      chk(sram_addr == a, "R7 hold addr", sram_addr, a);
      @(negedge clk);
      chk(req_ready && sram_cs_n && !sram_dq_oe, "R8 deselect",
          {req_ready, sram_cs_n, sram_dq_oe}, 3'b110);
      chk(!rsp_valid, "R10 no rsp", rsp_valid, 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // {write, address, data or expected read data}
  localparam logic [25:0] VEC [0:10] = '{
    {1'b1, 17'h00000, 8'h3C},
    {1'b1, 17'h1FFFF, 8'hC3},
    {1'b0, 17'h00000, 8'h3C},
    {1'b0, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0ABCD, 8'h5A},
    {1'b1, 17'h0ABCD, 8'hA5},
    {1'b0, 17'h0ABCD, 8'hA5},
    {1'b0, 17'h15555, BLANK},
    {1'b1, 17'h00001, 8'hFF},
    {1'b0, 17'h00001, 8'hFF},
    {1'b0, 17'h00000, 8'h3C}
  };

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && sram_cs_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe,
        "R1 reset pins", {req_ready, sram_cs_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe},
        6'b110110);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    chk(req_ready && sram_cs_n && !sram_ce, "R1 idle", {req_ready, sram_cs_n, sram_ce}, 3'b110);

    for (int i = 0; i < 11; i++) do_txn(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // Reset in the middle of a write strobe.
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00002; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!sram_we_n, "R5 in strobe", sram_we_n, 0);
    mon_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(req_ready && sram_cs_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe,
        "R1 abort pins", {req_ready, sram_cs_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe},
        6'b110110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    saw_desel = 1'b1;
    chk(!rsp_valid && req_ready, "R1 after abort", {rsp_valid, req_ready}, 2'b01);
    do_txn(1'b0, 17'h00000, 8'h3C);
    do_txn(1'b1, 17'h00003, 8'h81);
    do_txn(1'b0, 17'h00003, 8'h81);

    // Valid held low: nothing starts.
    repeat (4) begin
      @(negedge clk);
      chk(sram_cs_n && req_ready && !rsp_valid, "R2 no request",
          {sram_cs_n, req_ready, rsp_valid}, 3'b110);
    end
    finish_run();
  end

endmodule